// File: doc/BRIEF.md
# Serial-Bus Wiper Code Register

This block is a two-wire serial-bus target that owns a single 7-bit wiper control word. A bus controller selects it with a fixed 7-bit device address and a direction bit. In write direction, every data byte after the address replaces the stored word, and the block raises a one-cycle strobe so that downstream logic (a tap decoder, for example) can pick up the new code. In read direction, the block returns the stored word byte after byte for as long as the controller keeps acknowledging.

SCL and SDA are sampled with a much faster system clock through two-flop synchronizers. START and STOP are detected on the synchronized lines. The open-drain SDA pin is represented by an output enable: while `sda_oe` is high the pad pulls the line low, and while it is low the line is released. The system clock must run at least eight times faster than SCL.

Top module: `wiper_i2c_target`

## Requirements
- R1: After reset, `wiper_code` is 7'h40 (midscale), `sda_oe` is 0 and `wiper_update` is 0.
- R2: An address byte whose upper seven bits equal 7'b0101110 is acknowledged: SDA is held low for the whole ninth SCL clock. This holds for bit 0 = 0 (write, byte 8'h5C) and for bit 0 = 1 (read, byte 8'h5D).
- R3: In write direction, a data byte's low seven bits are loaded into `wiper_code`, and bit 7 is ignored. The byte is acknowledged, and `wiper_update` is high for exactly one system-clock cycle while that acknowledge is driven.
- R4: Every further data byte in the same write transfer updates `wiper_code` again and gives its own strobe, until a STOP or START.
- R5: When the address does not match, the block never drives SDA, gives no acknowledge, and leaves `wiper_code` unchanged until the next START or STOP.
- R6: In read direction, the block sends 0 as the first bit and then the stored code from its most significant bit down. Each bit is placed on SDA after a falling SCL edge.
- R7: While the controller acknowledges a read byte, the next byte repeats the stored code. After a not-acknowledge, SDA stays released until the next START or STOP.
- R8: A START in the middle of a byte aborts that byte without changing `wiper_code`. Address reception then starts again.
- R9: A STOP in the middle of a write data byte leaves `wiper_code` unchanged.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_code | output | 7 | Stored wiper control word |
| wiper_update | output | 1 | One-cycle pulse when a written byte is accepted |

## Verification
The hardest case to reach from the ports is a START or STOP that arrives partway through a byte. It needs a controller that stops clocking after a few bits and then moves SDA while SCL is high. The bench drives this with a bit-level controller model: it sends a partial byte and then issues the condition mid-byte. Afterwards it reads the register back through a fresh read transfer, to show that the aborted byte changed nothing and that address reception restarted cleanly. Read bytes are taken from the shared open-drain line, so the bench sees the bit timing exactly as a real controller would.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int CODE_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_IGNORE
  } xfer_state_t;

  // upper seven bits of an address byte compared with the device address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [CODE_W-1:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

  // code carried by a written byte: top bit discarded
  function automatic logic [CODE_W-1:0] code_of(input logic [BYTE_W-1:0] b);
    return b[CODE_W-1:0];
  endfunction

  // byte returned on a read: zero pad above the code
  function automatic logic [BYTE_W-1:0] read_image(input logic [CODE_W-1:0] w);
    return {{(BYTE_W-CODE_W){1'b0}}, w};
  endfunction
endpackage

// File: rtl/wiper_i2c_sync.sv
module wiper_i2c_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '1;
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wiper_i2c_bus_events.sv
module wiper_i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/wiper_i2c_engine.sv
module wiper_i2c_engine
  import wiper_i2c_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_ADDR   = 7'h2E,
  parameter logic [CODE_W-1:0] RESET_CODE = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              sda_oe,
  output logic [CODE_W-1:0] wiper_code,
  output logic              wiper_update,
  output logic              ignoring
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  xfer_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw, m_ack;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte  = {sh[BYTE_W-2:0], sda_s};
  assign ignoring = (state == ST_IGNORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      sh           <= '0;
      rw           <= 1'b0;
      m_ack        <= 1'b0;
      sda_oe       <= 1'b0;
      wiper_code   <= RESET_CODE;
      wiper_update <= 1'b0;
    end else begin
      wiper_update <= 1'b0;
      if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDATA: if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (state == ST_WDATA) state <= ST_WACK;
              else if (addr_hit(rx_byte, DEV_ADDR)) begin
                state <= ST_ADDR_ACK;
                rw    <= rx_byte[0];
              end else state <= ST_IGNORE;
            end
          end
          ST_ADDR_ACK, ST_WACK: if (scl_fall) begin
            if (cnt == '0) begin
              sda_oe <= 1'b1;
              cnt    <= CNT_W'(1);
              if (state == ST_WACK) begin
                wiper_code   <= code_of(sh);
                wiper_update <= 1'b1;
              end
            end else begin
              cnt <= '0;
              if (state == ST_ADDR_ACK && rw) begin
                sh     <= read_image(wiper_code);
                sda_oe <= ~read_image(wiper_code)[BYTE_W-1];
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                sda_oe <= ~sh[BYTE_W-2];
                sh     <= sh << 1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            else if (scl_fall) begin
              cnt <= '0;
              if (m_ack) begin
                sh     <= read_image(wiper_code);
                sda_oe <= ~read_image(wiper_code)[BYTE_W-1];
                state  <= ST_RDATA;
              end else state <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_i2c_target.sv
module wiper_i2c_target
  import wiper_i2c_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_ADDR    = 7'h2E,
  parameter logic [CODE_W-1:0] RESET_CODE  = 7'h40,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [CODE_W-1:0] wiper_code,
  output logic              wiper_update
);
  logic scl_sync, sda_sync;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic ignoring;

  wiper_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_sync, sda_sync})
  );

  wiper_i2c_bus_events events_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .sda_s(sda_sync),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  wiper_i2c_engine #(.DEV_ADDR(DEV_ADDR), .RESET_CODE(RESET_CODE)) engine_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_sync),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_oe(sda_oe), .wiper_code(wiper_code),
    .wiper_update(wiper_update), .ignoring(ignoring)
  );
endmodule

// File: rtl/wiper_i2c_checker.sv
module wiper_i2c_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_evt,
  input logic       ignoring,
  input logic       sda_oe,
  input logic [6:0] wiper_code,
  input logic       wiper_update
);
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_update |=> !wiper_update);

  a_r3_code_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_code) |-> wiper_update);

  a_r3_strobe_during_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_update |-> sda_oe);

  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r5_ignored_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
endmodule

bind wiper_i2c_target wiper_i2c_checker chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .start_evt(start_evt),
  .ignoring(ignoring), .sda_oe(sda_oe), .wiper_code(wiper_code),
  .wiper_update(wiper_update)
);

// File: tb/wiper_i2c_target_tb_top.sv
module wiper_i2c_target_tb_top;
  localparam int H = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wiper_update;
  logic [6:0] wiper_code;
  wire sda_line = sda_m & ~sda_oe;

  int n_cmp = 0, n_bad = 0;
  int oe_cnt = 0, oe_bad = 0;
  logic upd_prev = 1'b0, oe_prev = 1'b0;
  logic [6:0] exp_q[$];
  logic bit_v, ack_v;
  logic [7:0] byte_v;

  always #2 clk = ~clk;

  wiper_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper_code(wiper_code), .wiper_update(wiper_update)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected codes on each strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (wiper_update) begin
        if (upd_prev) chk("R3 strobe width", 8'd2, 8'd1);
        if (exp_q.size() == 0) chk("R4 unexpected strobe", {1'b0, wiper_code}, 8'hFF);
        else chk("R3/R4 strobe code", {1'b0, wiper_code}, {1'b0, exp_q.pop_front()});
      end
      if (sda_oe) oe_cnt++;
      if (sda_oe !== oe_prev && scl) oe_bad++;
    end
    upd_prev = wiper_update;
    oe_prev  = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_m = b; wt(H); scl = 1'b1; wt(H/2); seen = sda_line; wt(H/2);
    scl = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) clock_bit(b[i], bit_v);
    clock_bit(1'b1, bit_v);
    acked = ~bit_v;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, bit_v);
      b[i] = bit_v;
    end
    clock_bit(~give_ack, bit_v);
    sda_m = 1'b1;
  endtask

  task automatic write_xfer(input logic [7:0] d0, input logic [7:0] d1);
    bus_start();
    send_byte(8'h5C, ack_v); chk("R2 write address ack", {7'd0, ack_v}, 8'd1);
    exp_q.push_back(d0[6:0]);
    send_byte(d0, ack_v); chk("R3 data ack", {7'd0, ack_v}, 8'd1);
    exp_q.push_back(d1[6:0]);
    send_byte(d1, ack_v); chk("R4 second data ack", {7'd0, ack_v}, 8'd1);
    bus_stop();
    chk("R4 final code", {1'b0, wiper_code}, {1'b0, d1[6:0]});
  endtask

  task automatic read_one(input string req, input logic [6:0] exp);
    bus_start();
    send_byte(8'h5D, ack_v); chk("R2 read address ack", {7'd0, ack_v}, 8'd1);
    recv_byte(1'b0, byte_v); chk(req, byte_v, {1'b0, exp});
    bus_stop();
  endtask

  initial begin
    int snap;
    wt(10);
    chk("R1 reset code", {1'b0, wiper_code}, 8'h40);
    chk("R1 reset oe", {7'd0, sda_oe}, 8'd0);
    chk("R1 reset strobe", {7'd0, wiper_update}, 8'd0);
    rst_n = 1'b1; wt(10);

    read_one("R6 midscale readback", 7'h40);
    write_xfer(8'hA5, 8'h11);

    // R7 repeated read, then release after not-acknowledge
    bus_start();
    send_byte(8'h5D, ack_v); chk("R7 address ack", {7'd0, ack_v}, 8'd1);
    recv_byte(1'b1, byte_v); chk("R7 first byte", byte_v, 8'h11);
    recv_byte(1'b0, byte_v); chk("R7 second byte", byte_v, 8'h11);
    wt(H); chk("R7 released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();

    // R5 foreign address
    snap = oe_cnt;
    bus_start();
    send_byte(8'h5E, ack_v); chk("R5 no ack", {7'd0, ack_v}, 8'd0);
    send_byte(8'h7F, ack_v);
    bus_stop();
    chk("R5 never drove SDA", 8'(oe_cnt - snap), 8'd0);
    chk("R5 code kept", {1'b0, wiper_code}, 8'h11);

    // R8 repeated START after four data bits
    bus_start();
    send_byte(8'h5C, ack_v); chk("R8 address ack", {7'd0, ack_v}, 8'd1);
    for (int i = 0; i < 4; i++) clock_bit(i[0], bit_v);
    bus_start();
    send_byte(8'h5D, ack_v); chk("R8 address after restart", {7'd0, ack_v}, 8'd1);
    recv_byte(1'b0, byte_v); chk("R8 code unchanged", byte_v, 8'h11);
    bus_stop();

    // R9 STOP after three data bits
    bus_start();
    send_byte(8'h5C, ack_v);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, bit_v);
    bus_stop();
    chk("R9 code unchanged", {1'b0, wiper_code}, 8'h11);

    // boundaries
    write_xfer(8'h80, 8'hFF);
    read_one("R6 full-scale readback", 7'h7F);
    write_xfer(8'h7F, 8'h00);
    read_one("R6 zero readback", 7'h00);

    chk("R4 all strobes seen", 8'(exp_q.size()), 8'd0);
    chk("R10 oe moved only with SCL low", 8'(oe_bad), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule